// File: doc/BRIEF.md
# GPIO Edge and Level Interrupt Controller

This block watches a bank of general-purpose input pins and turns selected activity on them into one interrupt request. Each pin has its own configuration: whether it reacts to edges or to levels, whether an edge-mode pin reacts to both directions, which direction or level is active, and whether the pin may reach the interrupt output at all. Pin inputs are asynchronous to the block clock and pass through a two-flop synchroniser. Edges are found by comparing each synchronised sample with the one before it.

An edge event is held in a sticky status bit until software acknowledges it. Software acknowledges a pin by writing its bit of the clear register to 0 and then to 1; the sticky bit drops on the 0-to-1 change. A level-mode pin is not latched: its status follows the synchronised input and the selected level. Software can read both the raw status and the status after enable masking. The interrupt output is the OR of all masked status bits.

A simple word-wide register port carries 32 pins per word. Pin p lives in word p/32 at bit p%32 of every per-pin register. The address is made of two parts: the upper three bits select the register kind and the low bits select the word.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the trigger-type, both-edge, polarity, enable and clear registers read 0, no sticky status is held, and irq_o is 0.
- R2: An address is {kind[2:0], word}. The kind codes are: 0 trigger type, 1 both-edge, 2 polarity, 3 enable, 4 clear, 5 raw status (read-only), 6 masked status (read-only), 7 reads 0. A write with bus_we lands at the edge where it is sampled. bus_rdata shows the addressed word one clock after the address is presented. Pin p is bit p%32 of word p/32.
- R3: Each pin passes through two flops. A pin change driven before clock edge k is first seen by detection after edge k+1. An edge-mode event therefore shows on irq_o after edge k+2, and a level-mode change shows after edge k+1.
- R4: With type bit 1 (edge) and both-edge bit 0, polarity 1 catches rising edges and polarity 0 catches falling edges. The event sets a sticky status bit, which stays set after the pin returns.
- R5: With type 1 and both-edge 1, both rising and falling edges set the sticky bit, whatever the polarity bit holds.
- R6: With type 0 (level), the raw status bit is 1 while the synchronised pin equals the polarity bit (1 for high, 0 for low). It is not latched, and the both-edge bit has no effect.
- R7: A sticky bit clears only at the write that takes its clear-register bit from 0 to 1. Writing 0, or writing 1 over a 1, leaves the status unchanged.
- R8: When an edge event and a clearing 0-to-1 write fall on the same clock edge, the event wins and the sticky bit stays set.
- R9: Masked status is raw status AND enable, and irq_o is the OR of masked status. A disabled pin still records its raw status. Clearing the enable bit and then pulsing the clear bit leaves both irq_o and that pin's status at 0.
- R10: Writes to the raw-status, masked-status and unused kinds change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 64 | Asynchronous pin levels, one per pin |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | {kind[2:0], word}, as in R2 |
| bus_wdata | input | 32 | Write data word |
| bus_rdata | output | 32 | Registered read data of the addressed word |
| irq_o | output | 1 | OR of all enabled status bits |

## Verification
The two functions that can fall in the same cycle are a new edge on a pin and the software acknowledge of that same pin. The bench lines up a pin toggle so that its detected edge sits on the very clock edge where a clear write rises from 0 to 1. It then expects irq_o to stay high and the raw status bit to stay set. A random phase also toggles pins while it writes clear words at random, and a cycle-level bench model judges each such collision the same way.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int WORD_BITS = 32;
  localparam int KIND_W    = 3;

  typedef enum logic [KIND_W-1:0] {
    K_TYPE = 3'd0,
    K_BOTH = 3'd1,
    K_POL  = 3'd2,
    K_EN   = 3'd3,
    K_CLR  = 3'd4,
    K_RAW  = 3'd5,
    K_MSK  = 3'd6,
    K_NONE = 3'd7
  } reg_kind_e;

  // edge detection on one pin: cur/prv are successive synchronised samples
  function automatic logic edge_hit(input logic cur, input logic prv,
                                    input logic both, input logic pol);
    if (both) return cur ^ prv;
    return pol ? (cur & ~prv) : (~cur & prv);
  endfunction

  // level match on one pin
  function automatic logic level_hit(input logic cur, input logic pol);
    return ~(cur ^ pol);
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int NUM_PINS = 64,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] prev_o
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], pin_i[p]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_o[p]  = chain_q[STAGES-1];
    assign prev_o[p] = prev_q;
  end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter  int NUM_PINS  = 64,
  localparam int NUM_WORDS = (NUM_PINS + WORD_BITS - 1) / WORD_BITS,
  localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W    = KIND_W + WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_BITS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0]  raw_i,
  input  logic [NUM_PINS-1:0]  msk_i,
  output logic [NUM_PINS-1:0]  type_o,
  output logic [NUM_PINS-1:0]  both_o,
  output logic [NUM_PINS-1:0]  pol_o,
  output logic [NUM_PINS-1:0]  en_o,
  output logic [NUM_PINS-1:0]  clr_rise_o,
  output logic [WORD_BITS-1:0] rdata_o
);

  localparam int PAD = NUM_WORDS * WORD_BITS;

  // bits of word w that map to a real pin
  function automatic logic [WORD_BITS-1:0] valid_bits(input int w);
    logic [WORD_BITS-1:0] v;
    for (int b = 0; b < WORD_BITS; b++) v[b] = ((w * WORD_BITS + b) < NUM_PINS);
    return v;
  endfunction

  logic [PAD-1:0] type_r, both_r, pol_r, en_r, clr_r;
  logic [PAD-1:0] rise_pad, raw_pad, msk_pad, rd_vec;
  reg_kind_e      kind;
  int             widx;

  assign kind    = reg_kind_e'(addr_i[ADDR_W-1 -: KIND_W]);
  assign widx    = int'(addr_i[WORD_W-1:0]);
  assign raw_pad = PAD'(raw_i);
  assign msk_pad = PAD'(msk_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_r <= '0;
      both_r <= '0;
      pol_r  <= '0;
      en_r   <= '0;
      clr_r  <= '0;
    end else if (we_i) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (widx == w) begin
          unique case (kind)
            K_TYPE: type_r[w*WORD_BITS +: WORD_BITS] <= wdata_i & valid_bits(w);
            K_BOTH: both_r[w*WORD_BITS +: WORD_BITS] <= wdata_i & valid_bits(w);
            K_POL:  pol_r [w*WORD_BITS +: WORD_BITS] <= wdata_i & valid_bits(w);
            K_EN:   en_r  [w*WORD_BITS +: WORD_BITS] <= wdata_i & valid_bits(w);
            K_CLR:  clr_r [w*WORD_BITS +: WORD_BITS] <= wdata_i & valid_bits(w);
            default: ;
          endcase
        end
      end
    end
  end

  // a clear bit going 0 -> 1 in this write acknowledges that pin
  always_comb begin
    rise_pad = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (we_i && (widx == w) && (kind == K_CLR))
        rise_pad[w*WORD_BITS +: WORD_BITS] =
          wdata_i & valid_bits(w) & ~clr_r[w*WORD_BITS +: WORD_BITS];
    end
  end

  always_comb begin
    unique case (kind)
      K_TYPE:  rd_vec = type_r;
      K_BOTH:  rd_vec = both_r;
      K_POL:   rd_vec = pol_r;
      K_EN:    rd_vec = en_r;
      K_CLR:   rd_vec = clr_r;
      K_RAW:   rd_vec = raw_pad;
      K_MSK:   rd_vec = msk_pad;
      default: rd_vec = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rdata_o <= '0;
    else if (widx < NUM_WORDS) rdata_o <= rd_vec[widx*WORD_BITS +: WORD_BITS];
    else                       rdata_o <= '0;
  end

  assign type_o     = type_r[NUM_PINS-1:0];
  assign both_o     = both_r[NUM_PINS-1:0];
  assign pol_o      = pol_r[NUM_PINS-1:0];
  assign en_o       = en_r[NUM_PINS-1:0];
  assign clr_rise_o = rise_pad[NUM_PINS-1:0];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] prev_i,
  input  logic [NUM_PINS-1:0] type_i,
  input  logic [NUM_PINS-1:0] both_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] clr_rise_i,
  output logic [NUM_PINS-1:0] edge_ev_o,
  output logic [NUM_PINS-1:0] sticky_o,
  output logic [NUM_PINS-1:0] raw_o
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic ev, lv, st_q;

    assign ev = edge_hit(lvl_i[p], prev_i[p], both_i[p], pol_i[p]);
    assign lv = level_hit(lvl_i[p], pol_i[p]);

    // new event outranks acknowledge; level mode keeps nothing latched
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         st_q <= 1'b0;
      else if (!type_i[p]) st_q <= 1'b0;
      else if (ev)         st_q <= 1'b1;
      else if (clr_rise_i[p]) st_q <= 1'b0;
    end

    assign edge_ev_o[p] = ev;
    assign sticky_o[p]  = st_q;
    assign raw_o[p]     = type_i[p] ? st_q : lv;
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter  int NUM_PINS  = 64,
  localparam int NUM_WORDS = (NUM_PINS + WORD_BITS - 1) / WORD_BITS,
  localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W    = KIND_W + WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  pin_in,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_BITS-1:0] bus_wdata,
  output logic [WORD_BITS-1:0] bus_rdata,
  output logic                 irq_o
);

  logic [NUM_PINS-1:0] sync_lvl, sync_prev;
  logic [NUM_PINS-1:0] cfg_type, cfg_both, cfg_pol, cfg_en;
  logic [NUM_PINS-1:0] clr_rise, edge_ev, sticky, raw_stat, msk_stat;

  gpio_irq_sync #(.NUM_PINS(NUM_PINS), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_in),
    .lvl_o  (sync_lvl),
    .prev_o (sync_prev)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (bus_we),
    .addr_i     (bus_addr),
    .wdata_i    (bus_wdata),
    .raw_i      (raw_stat),
    .msk_i      (msk_stat),
    .type_o     (cfg_type),
    .both_o     (cfg_both),
    .pol_o      (cfg_pol),
    .en_o       (cfg_en),
    .clr_rise_o (clr_rise),
    .rdata_o    (bus_rdata)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (sync_lvl),
    .prev_i     (sync_prev),
    .type_i     (cfg_type),
    .both_i     (cfg_both),
    .pol_i      (cfg_pol),
    .clr_rise_i (clr_rise),
    .edge_ev_o  (edge_ev),
    .sticky_o   (sticky),
    .raw_o      (raw_stat)
  );

  assign msk_stat = raw_stat & cfg_en;
  assign irq_o    = |msk_stat;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int NUM_PINS = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] lvl,
  input logic [NUM_PINS-1:0] type_q,
  input logic [NUM_PINS-1:0] pol_q,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] raw,
  input logic [NUM_PINS-1:0] sticky,
  input logic [NUM_PINS-1:0] edge_ev,
  input logic [NUM_PINS-1:0] clr_rise,
  input logic                irq_o
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (lvl == $past(pin_in, 2)));

  assert_irq_is_masked_or_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(raw & en_q)));

  assert_edge_sets_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_ev & type_q)) |=>
      ((sticky & $past(edge_ev & type_q)) == $past(edge_ev & type_q)));

  assert_sticky_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sticky & type_q & ~clr_rise)) |=>
      ((sticky & $past(sticky & type_q & ~clr_rise)) == $past(sticky & type_q & ~clr_rise)));

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_rise & ~edge_ev & type_q)) |=>
      ((sticky & $past(clr_rise & ~edge_ev & type_q)) == '0));

  assert_level_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~type_q) == (~(lvl ^ pol_q) & ~type_q)));

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_in   (pin_in),
  .lvl      (sync_lvl),
  .type_q   (cfg_type),
  .pol_q    (cfg_pol),
  .en_q     (cfg_en),
  .raw      (raw_stat),
  .sticky   (sticky),
  .edge_ev  (edge_ev),
  .clr_rise (clr_rise),
  .irq_o    (irq_o)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 64;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_o;

  int n_checks = 0;
  int n_fail = 0;

  // bench model state
  logic [NP-1:0] m_type = '0, m_both = '0, m_pol = '0, m_en = '0, m_clr = '0;
  logic [NP-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_sticky = '0;
  logic [31:0]   m_rdata = '0;

  gpio_irq_ctrl #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NP-1:0] f_event(logic [NP-1:0] now, logic [NP-1:0] old,
                                            logic [NP-1:0] both, logic [NP-1:0] pol);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) begin
      if (both[i])     r[i] = (now[i] != old[i]);
      else if (pol[i]) r[i] = now[i] && !old[i];
      else             r[i] = old[i] && !now[i];
    end
    return r;
  endfunction

  function automatic logic [NP-1:0] f_raw();
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++)
      r[i] = m_type[i] ? m_sticky[i] : (m_s2[i] == m_pol[i]);
    return r;
  endfunction

  function automatic logic [31:0] f_read(logic [2:0] k, int w);
    logic [NP-1:0] v;
    case (k)
      3'd0: v = m_type;
      3'd1: v = m_both;
      3'd2: v = m_pol;
      3'd3: v = m_en;
      3'd4: v = m_clr;
      3'd5: v = f_raw();
      3'd6: v = f_raw() & m_en;
      default: v = '0;
    endcase
    return v[w*32 +: 32];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock: predict, advance, compare against model at the falling edge
  task automatic tick();
    logic [NP-1:0] ev, rise, nst, pin_s;
    logic [31:0]   nrd, wd;
    logic [2:0]    k;
    logic          we;
    int            w;
    k = bus_addr[3:1]; w = int'(bus_addr[0]); we = bus_we; wd = bus_wdata; pin_s = pin_in;
    ev = f_event(m_s2, m_prev, m_both, m_pol);
    rise = '0;
    if (we && k == 3'd4) rise[w*32 +: 32] = wd & ~m_clr[w*32 +: 32];
    nst = m_type & ((m_sticky & ~rise) | ev);
    nrd = f_read(k, w);
    @(posedge clk);
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_s;
    m_sticky = nst; m_rdata = nrd;
    if (we) begin
      case (k)
        3'd0: m_type[w*32 +: 32] = wd;
        3'd1: m_both[w*32 +: 32] = wd;
        3'd2: m_pol[w*32 +: 32]  = wd;
        3'd3: m_en[w*32 +: 32]   = wd;
        3'd4: m_clr[w*32 +: 32]  = wd;
        default: ;
      endcase
    end
    @(negedge clk);
    chk(irq_o == (|(f_raw() & m_en)), "R9", {31'd0, irq_o}, {31'd0, |(f_raw() & m_en)}, "model irq");
    chk(bus_rdata == m_rdata, "R2", bus_rdata, m_rdata, "model rdata");
  endtask

  task automatic wr(logic [2:0] k, int w, logic [31:0] d);
    bus_we = 1'b1; bus_addr = {k, w[0]}; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] k, int w, output logic [31:0] d);
    bus_addr = {k, w[0]};
    tick();
    d = bus_rdata;
  endtask

  task automatic rdchk(logic [2:0] k, int w, logic [31:0] exp, string req);
    logic [31:0] d;
    rd(k, w, d);
    chk(d == exp, req, d, exp, $sformatf("read kind %0d word %0d", k, w));
  endtask

  task automatic irqchk(bit exp, string req, string what);
    chk(irq_o == exp, req, {31'd0, irq_o}, {31'd0, exp}, what);
  endtask

  task automatic ack3();   // clear bit of pin 3 with a 0-then-1 pattern
    wr(3'd4, 0, 32'h0);
    wr(3'd4, 0, 32'h8);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // held reset state; model is all zero with rdata 0
    tick();

    // R1 reset values
    irqchk(1'b0, "R1", "irq after reset");
    for (int k = 0; k < 5; k++) begin
      rdchk(3'(k), 0, 32'h0, "R1");
      rdchk(3'(k), 1, 32'h0, "R1");
    end
    rdchk(3'd5, 0, 32'hFFFF_FFFF, "R6");   // low-level default, pins low
    rdchk(3'd6, 0, 32'h0, "R1");

    // R2 word/bit placement: pin 40 is word 1 bit 8
    wr(3'd0, 1, 32'h0000_0100);
    rdchk(3'd0, 1, 32'h0000_0100, "R2");
    rdchk(3'd0, 0, 32'h0, "R2");
    wr(3'd0, 1, 32'h0);

    // R10 writes to read-only kinds
    wr(3'd5, 0, 32'h0);
    rdchk(3'd5, 0, 32'hFFFF_FFFF, "R10");
    wr(3'd6, 0, 32'hFFFF_FFFF);
    rdchk(3'd6, 0, 32'h0, "R10");
    wr(3'd7, 0, 32'hFFFF_FFFF);
    rdchk(3'd0, 0, 32'h0, "R10");

    // R4 rising edge on pin 3, with R3 latency
    wr(3'd0, 0, 32'h8);
    wr(3'd2, 0, 32'h8);
    wr(3'd3, 0, 32'h8);
    irqchk(1'b0, "R4", "idle before edge");
    pin_in[3] = 1'b1;
    tick(); irqchk(1'b0, "R3", "edge +1");
    tick(); irqchk(1'b0, "R3", "edge +2");
    tick(); irqchk(1'b1, "R4", "rising edge latched");
    pin_in[3] = 1'b0;
    repeat (3) tick();
    irqchk(1'b1, "R4", "sticky after fall");

    // R7 acknowledge rules
    wr(3'd4, 0, 32'h0);
    irqchk(1'b1, "R7", "write 0 keeps status");
    wr(3'd4, 0, 32'h8);
    irqchk(1'b0, "R7", "0-to-1 clears");
    pin_in[3] = 1'b1;
    repeat (3) tick();
    irqchk(1'b1, "R4", "second rising edge");
    wr(3'd4, 0, 32'h8);
    irqchk(1'b1, "R7", "1 over 1 keeps status");
    ack3();
    irqchk(1'b0, "R7", "ack after re-arm");

    // R5 both edges, polarity ignored
    wr(3'd1, 0, 32'h8);
    pin_in[3] = 1'b0;
    repeat (3) tick();
    irqchk(1'b1, "R5", "falling caught in both mode");
    ack3();
    pin_in[3] = 1'b1;
    repeat (3) tick();
    irqchk(1'b1, "R5", "rising caught in both mode");
    ack3();
    irqchk(1'b0, "R5", "both mode acked");

    // R8 event and acknowledge on the same edge
    wr(3'd4, 0, 32'h0);
    pin_in[3] = 1'b0;
    tick(); tick();
    wr(3'd4, 0, 32'h8);
    irqchk(1'b1, "R8", "event wins over clear");
    rdchk(3'd5, 0, 32'hFFFF_FFFF, "R8");
    ack3();
    irqchk(1'b0, "R8", "later clear works");

    // R9 enable gating and mask-then-ack
    wr(3'd3, 0, 32'h0);
    pin_in[3] = 1'b1;
    repeat (3) tick();
    irqchk(1'b0, "R9", "disabled pin silent");
    rdchk(3'd6, 0, 32'h0, "R9");
    wr(3'd3, 0, 32'h8);
    irqchk(1'b1, "R9", "enable exposes raw status");
    wr(3'd3, 0, 32'h0);
    ack3();
    irqchk(1'b0, "R9", "mask then ack");
    rdchk(3'd5, 0, 32'hFFFF_FFF7, "R9");

    // R6 level mode on pin 40, both-edge set but ignored
    wr(3'd2, 1, 32'h0000_0100);
    wr(3'd1, 1, 32'h0000_0100);
    wr(3'd3, 1, 32'h0000_0100);
    irqchk(1'b0, "R6", "high level not present");
    pin_in[40] = 1'b1;
    tick(); irqchk(1'b0, "R3", "level +1");
    tick(); irqchk(1'b1, "R6", "high level seen");
    pin_in[40] = 1'b0;
    tick(); irqchk(1'b1, "R3", "level drop +1");
    tick(); irqchk(1'b0, "R6", "level not latched");
    wr(3'd2, 1, 32'h0);
    irqchk(1'b1, "R6", "low level active");
    wr(3'd3, 1, 32'h0);

    // random phase against the bench model
    for (int c = 0; c < 4000; c++) begin
      pin_in = pin_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      bus_addr = 4'($urandom);
      bus_we = ($urandom % 2) == 0;
      bus_wdata = $urandom;
      if (($urandom % 4) == 0) begin
        bus_addr = {3'd4, 1'($urandom)};
        bus_wdata = $urandom & $urandom;
      end
      tick();
      bus_we = 1'b0;
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule